// File: doc/BRIEF.md
# Integer ALU with Shifter

A purely combinational 32-bit integer execution unit for a classic load/store RISC core. Each cycle it receives the two register operands (`rsVal`, `rtVal`), the 5-bit shift-amount field, the 6-bit primary opcode, the 6-bit function code and the 16-bit immediate. It decodes the operation straight from the opcode/function pair and returns one result word. It also returns two exception indications: a signed-overflow trap and a reserved-instruction flag. Each comes with its exception cause code.

The unit covers add/subtract (trapping and wrapping forms), the four bitwise logic operations, set-on-less-than (signed and unsigned), load-upper-immediate, and the six shift forms. For I-format operations it extends the immediate itself. The surrounding pipeline uses the exception outputs to suppress writeback and enter the trap handler.

Top module: `int_alu`

## Requirements
- R1: With opcode 0x00, function codes 0x20 (add), 0x21 (addu), 0x22 (sub) and 0x23 (subu) give rs+rt or rs-rt modulo 2^32.
- R2: With opcode 0x00, function codes 0x24, 0x25, 0x26 and 0x27 give rs AND rt, rs OR rt, rs XOR rt and NOT(rs OR rt).
- R3: `ovfTrap` is 1 only for add (funct 0x20), sub (funct 0x22) and addi (opcode 0x08), and only when the two's-complement result overflows. Then `excCode` is 0x0C and `result` still carries the wrapped value. addu, subu and addiu (opcode 0x09) never raise it.
- R4: Opcodes 0x08 addi, 0x09 addiu, 0x0A slti and 0x0B sltiu use the immediate sign-extended. Opcodes 0x0C andi, 0x0D ori and 0x0E xori use it zero-extended.
- R5: Opcode 0x0F (lui) returns the immediate in bits 31:16 with bits 15:0 cleared, whatever rs holds.
- R6: slt (funct 0x2A) and slti (opcode 0x0A) compare signed; sltu (funct 0x2B) and sltiu (opcode 0x0B) compare unsigned. sltiu uses the sign-extended immediate. The result is 1 or 0 in bit 0 with bits 31:1 zero, and these operations never raise the overflow trap.
- R7: Fixed shifts sll (funct 0x00), srl (0x02) and sra (0x03) shift rt by the 5-bit shift field; rs has no effect.
- R8: Variable shifts sllv (0x04), srlv (0x06) and srav (0x07) shift rt by bits 4:0 of rs; the upper bits of rs and the shift field have no effect.
- R9: srl and srlv fill vacated upper bits with zeros; sra and srav fill them with copies of rt bit 31.
- R10: Any opcode other than 0x00 and 0x08-0x0F, or opcode 0x00 with a function code not listed in R1, R2, R6, R7 or R8, sets `resvInstr`. It also forces `excCode` to 0x0A and `result` to zero, and keeps `ovfTrap` low. With no exception, `excCode` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rsVal | input | 32 | First source operand (rs register value) |
| rtVal | input | 32 | Second source operand (rt register value) |
| shamt | input | 5 | Shift-amount field of the instruction |
| opcode | input | 6 | Primary opcode field |
| funct | input | 6 | Function code field (used when opcode is 0x00) |
| imm | input | 16 | Immediate field of I-format instructions |
| result | output | 32 | Operation result |
| ovfTrap | output | 1 | Signed arithmetic overflow exception |
| resvInstr | output | 1 | Unrecognised opcode/function pair |
| excCode | output | 5 | Exception cause code: 0x0C overflow, 0x0A reserved, 0x00 none |

## Verification
The two functions that can coincide in one evaluation are the overflow detector and the reserved-instruction decode. Both are active when an unrecognised opcode arrives with function code 0x20 and operands that would overflow an addition. The bench drives exactly that pairing (opcode 0x01 with funct 0x20, 0x7FFFFFFF plus 1). It expects the reserved flag to win: result zero, cause 0x0A, no overflow trap. A second case exercises the shared adder for a compare whose internal subtraction overflows (slt of 0x80000000 against 0x7FFFFFFF). There the bench expects a result of 1 and no trap.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;

  localparam int OPC_W = 6;
  localparam int FN_W  = 6;
  localparam int EXC_W = 5;

  // primary opcodes
  localparam logic [OPC_W-1:0] OPC_RTYPE = 6'h00;
  localparam logic [OPC_W-1:0] OPC_ADDI  = 6'h08;
  localparam logic [OPC_W-1:0] OPC_ADDIU = 6'h09;
  localparam logic [OPC_W-1:0] OPC_SLTI  = 6'h0A;
  localparam logic [OPC_W-1:0] OPC_SLTIU = 6'h0B;
  localparam logic [OPC_W-1:0] OPC_ANDI  = 6'h0C;
  localparam logic [OPC_W-1:0] OPC_ORI   = 6'h0D;
  localparam logic [OPC_W-1:0] OPC_XORI  = 6'h0E;
  localparam logic [OPC_W-1:0] OPC_LUI   = 6'h0F;

  // function codes under OPC_RTYPE
  localparam logic [FN_W-1:0] FN_SLL  = 6'h00;
  localparam logic [FN_W-1:0] FN_SRL  = 6'h02;
  localparam logic [FN_W-1:0] FN_SRA  = 6'h03;
  localparam logic [FN_W-1:0] FN_SLLV = 6'h04;
  localparam logic [FN_W-1:0] FN_SRLV = 6'h06;
  localparam logic [FN_W-1:0] FN_SRAV = 6'h07;
  localparam logic [FN_W-1:0] FN_ADD  = 6'h20;
  localparam logic [FN_W-1:0] FN_ADDU = 6'h21;
  localparam logic [FN_W-1:0] FN_SUB  = 6'h22;
  localparam logic [FN_W-1:0] FN_SUBU = 6'h23;
  localparam logic [FN_W-1:0] FN_AND  = 6'h24;
  localparam logic [FN_W-1:0] FN_OR   = 6'h25;
  localparam logic [FN_W-1:0] FN_XOR  = 6'h26;
  localparam logic [FN_W-1:0] FN_NOR  = 6'h27;
  localparam logic [FN_W-1:0] FN_SLT  = 6'h2A;
  localparam logic [FN_W-1:0] FN_SLTU = 6'h2B;

  // exception cause codes
  localparam logic [EXC_W-1:0] EXC_NONE = 5'h00;
  localparam logic [EXC_W-1:0] EXC_RESV = 5'h0A;
  localparam logic [EXC_W-1:0] EXC_OVF  = 5'h0C;

  typedef enum logic [3:0] {
    SEL_ADD, SEL_SUB, SEL_AND, SEL_OR, SEL_XOR, SEL_NOR,
    SEL_SLT, SEL_SLTU, SEL_SHL, SEL_SHR, SEL_LUI, SEL_ZERO
  } aluSel_e;

  // strobes from decode to datapath
  typedef struct packed {
    aluSel_e sel;
    logic    useImm;
    logic    zeroExtImm;
    logic    varShift;
    logic    arithShift;
    logic    trapOvf;
    logic    resv;
  } aluCtrl_t;

endpackage

// File: rtl/int_alu_ctrl.sv
module int_alu_ctrl
  import int_alu_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  input  logic [FN_W-1:0]  funct,
  output aluCtrl_t         ctrl
);

  always_comb begin
    ctrl      = '0;
    ctrl.sel  = SEL_ZERO;
    ctrl.resv = 1'b0;
    unique case (opcode)
      OPC_RTYPE: begin
        unique case (funct)
          FN_ADD:  begin ctrl.sel = SEL_ADD; ctrl.trapOvf = 1'b1; end
          FN_ADDU: ctrl.sel = SEL_ADD;
          FN_SUB:  begin ctrl.sel = SEL_SUB; ctrl.trapOvf = 1'b1; end
          FN_SUBU: ctrl.sel = SEL_SUB;
          FN_AND:  ctrl.sel = SEL_AND;
          FN_OR:   ctrl.sel = SEL_OR;
          FN_XOR:  ctrl.sel = SEL_XOR;
          FN_NOR:  ctrl.sel = SEL_NOR;
          FN_SLT:  ctrl.sel = SEL_SLT;
          FN_SLTU: ctrl.sel = SEL_SLTU;
          FN_SLL:  ctrl.sel = SEL_SHL;
          FN_SRL:  ctrl.sel = SEL_SHR;
          FN_SRA:  begin ctrl.sel = SEL_SHR; ctrl.arithShift = 1'b1; end
          FN_SLLV: begin ctrl.sel = SEL_SHL; ctrl.varShift = 1'b1; end
          FN_SRLV: begin ctrl.sel = SEL_SHR; ctrl.varShift = 1'b1; end
          FN_SRAV: begin
            ctrl.sel        = SEL_SHR;
            ctrl.varShift   = 1'b1;
            ctrl.arithShift = 1'b1;
          end
          default: ctrl.resv = 1'b1;
        endcase
      end
      OPC_ADDI:  begin ctrl.sel = SEL_ADD;  ctrl.useImm = 1'b1; ctrl.trapOvf = 1'b1; end
      OPC_ADDIU: begin ctrl.sel = SEL_ADD;  ctrl.useImm = 1'b1; end
      OPC_SLTI:  begin ctrl.sel = SEL_SLT;  ctrl.useImm = 1'b1; end
      OPC_SLTIU: begin ctrl.sel = SEL_SLTU; ctrl.useImm = 1'b1; end
      OPC_ANDI:  begin ctrl.sel = SEL_AND;  ctrl.useImm = 1'b1; ctrl.zeroExtImm = 1'b1; end
      OPC_ORI:   begin ctrl.sel = SEL_OR;   ctrl.useImm = 1'b1; ctrl.zeroExtImm = 1'b1; end
      OPC_XORI:  begin ctrl.sel = SEL_XOR;  ctrl.useImm = 1'b1; ctrl.zeroExtImm = 1'b1; end
      OPC_LUI:   ctrl.sel = SEL_LUI;
      default:   ctrl.resv = 1'b1;
    endcase
  end

endmodule

// File: rtl/int_alu_shifter.sv
module int_alu_shifter #(
  parameter int DATA_W = 32,
  parameter int SH_W   = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] din,
  input  logic [SH_W-1:0]   amt,
  input  logic              goLeft,
  input  logic              arith,
  output logic [DATA_W-1:0] dout
);

  function automatic logic [DATA_W-1:0] flipBits(input logic [DATA_W-1:0] v);
    logic [DATA_W-1:0] r;
    for (int i = 0; i < DATA_W; i++) r[i] = v[DATA_W-1-i];
    return r;
  endfunction

  logic              fillBit;
  logic [DATA_W-1:0] stg [SH_W+1];

  // left shifts reuse the right-shift stages on a mirrored word
  assign fillBit = arith & ~goLeft & din[DATA_W-1];
  assign stg[0]  = goLeft ? flipBits(din) : din;

  generate
    for (genvar g = 0; g < SH_W; g++) begin : gStage
      localparam int STEP = 1 << g;
      assign stg[g+1] = amt[g] ? {{STEP{fillBit}}, stg[g][DATA_W-1:STEP]} : stg[g];
    end
  endgenerate

  assign dout = goLeft ? flipBits(stg[SH_W]) : stg[SH_W];

  // R9: logical right shift by a non-zero amount clears the top bit
  always_comb begin
    if (!goLeft && !arith && amt != '0)
      assert_zero_fill_R9: assert (dout[DATA_W-1] == 1'b0);
  end

endmodule

// File: rtl/int_alu_datapath.sv
module int_alu_datapath
  import int_alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16,
  parameter int SH_W   = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] rsVal,
  input  logic [DATA_W-1:0] rtVal,
  input  logic [SH_W-1:0]   shamt,
  input  logic [IMM_W-1:0]  imm,
  input  aluCtrl_t          ctrl,
  output logic [DATA_W-1:0] result,
  output logic              ovf
);

  localparam int MSB   = DATA_W - 1;
  localparam int EXT_W = DATA_W - IMM_W;

  logic [DATA_W-1:0] immExt;
  logic [DATA_W-1:0] opB;
  logic [DATA_W-1:0] bEff;
  logic [DATA_W:0]   sumFull;
  logic [DATA_W-1:0] sum;
  logic              isSub;
  logic              signedOvf;
  logic              lessSigned;
  logic              lessUnsigned;
  logic [SH_W-1:0]   shAmt;
  logic [DATA_W-1:0] shOut;

  assign immExt = ctrl.zeroExtImm ? {{EXT_W{1'b0}}, imm} : {{EXT_W{imm[IMM_W-1]}}, imm};
  assign opB    = ctrl.useImm ? immExt : rtVal;

  // one adder serves add, subtract and both compares
  assign isSub   = (ctrl.sel == SEL_SUB) || (ctrl.sel == SEL_SLT) || (ctrl.sel == SEL_SLTU);
  assign bEff    = isSub ? ~opB : opB;
  assign sumFull = {1'b0, rsVal} + {1'b0, bEff} + {{DATA_W{1'b0}}, isSub};
  assign sum     = sumFull[MSB:0];

  assign signedOvf    = (rsVal[MSB] == bEff[MSB]) && (sum[MSB] != rsVal[MSB]);
  assign lessSigned   = sum[MSB] ^ signedOvf;
  assign lessUnsigned = ~sumFull[DATA_W];

  assign shAmt = ctrl.varShift ? rsVal[SH_W-1:0] : shamt;

  int_alu_shifter #(.DATA_W(DATA_W), .SH_W(SH_W)) u_shifter (
    .din    (rtVal),
    .amt    (shAmt),
    .goLeft (ctrl.sel == SEL_SHL),
    .arith  (ctrl.arithShift),
    .dout   (shOut)
  );

  always_comb begin
    unique case (ctrl.sel)
      SEL_ADD, SEL_SUB: result = sum;
      SEL_AND:          result = rsVal & opB;
      SEL_OR:           result = rsVal | opB;
      SEL_XOR:          result = rsVal ^ opB;
      SEL_NOR:          result = ~(rsVal | opB);
      SEL_SLT:          result = {{(DATA_W-1){1'b0}}, lessSigned};
      SEL_SLTU:         result = {{(DATA_W-1){1'b0}}, lessUnsigned};
      SEL_SHL, SEL_SHR: result = shOut;
      SEL_LUI:          result = {imm, {EXT_W{1'b0}}};
      default:          result = '0;
    endcase
  end

  assign ovf = ctrl.trapOvf & signedOvf;

  always_comb begin
    // R6: compares produce only bit 0
    if (ctrl.sel == SEL_SLT || ctrl.sel == SEL_SLTU)
      assert_set_bit_only_R6: assert (result[MSB:1] == '0);
    // R5: upper-immediate leaves the low half clear
    if (ctrl.sel == SEL_LUI)
      assert_lui_low_clear_R5: assert (result[EXT_W-1:0] == '0);
    // R3: a trapped sum has the opposite sign of rs
    if (ovf)
      assert_ovf_sign_flip_R3: assert (result[MSB] != rsVal[MSB]);
  end

endmodule

// File: rtl/int_alu.sv
module int_alu
  import int_alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16,
  parameter int SH_W   = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] rsVal,
  input  logic [DATA_W-1:0] rtVal,
  input  logic [SH_W-1:0]   shamt,
  input  logic [OPC_W-1:0]  opcode,
  input  logic [FN_W-1:0]   funct,
  input  logic [IMM_W-1:0]  imm,
  output logic [DATA_W-1:0] result,
  output logic              ovfTrap,
  output logic              resvInstr,
  output logic [EXC_W-1:0]  excCode
);

  aluCtrl_t ctrl;

  int_alu_ctrl u_ctrl (
    .opcode (opcode),
    .funct  (funct),
    .ctrl   (ctrl)
  );

  int_alu_datapath #(.DATA_W(DATA_W), .IMM_W(IMM_W), .SH_W(SH_W)) u_datapath (
    .rsVal  (rsVal),
    .rtVal  (rtVal),
    .shamt  (shamt),
    .imm    (imm),
    .ctrl   (ctrl),
    .result (result),
    .ovf    (ovfTrap)
  );

  assign resvInstr = ctrl.resv;
  assign excCode   = ovfTrap ? EXC_OVF : (resvInstr ? EXC_RESV : EXC_NONE);

  always_comb begin
    // R10: reserved pairs yield zero and never trap
    if (resvInstr)
      assert_resv_quiet_R10: assert (result == '0 && !ovfTrap);
    // R3: only add, sub and addi may trap
    if (ovfTrap)
      assert_trap_source_R3: assert (opcode == OPC_ADDI ||
                                     (opcode == OPC_RTYPE && (funct == FN_ADD || funct == FN_SUB)));
  end

endmodule

// File: tb/int_alu_tb.sv
module int_alu_tb;

  logic        clk = 1'b0;
  logic [31:0] rsVal = '0;
  logic [31:0] rtVal = '0;
  logic [4:0]  shamt = '0;
  logic [5:0]  opcode = '0;
  logic [5:0]  funct = '0;
  logic [15:0] imm = '0;
  logic [31:0] result;
  logic        ovfTrap;
  logic        resvInstr;
  logic [4:0]  excCode;

  int checkCount = 0;
  int failCount  = 0;
  bit finished   = 1'b0;

  always #5ns clk = ~clk;

  int_alu u_dut (
    .rsVal     (rsVal),
    .rtVal     (rtVal),
    .shamt     (shamt),
    .opcode    (opcode),
    .funct     (funct),
    .imm       (imm),
    .result    (result),
    .ovfTrap   (ovfTrap),
    .resvInstr (resvInstr),
    .excCode   (excCode)
  );

  typedef struct packed {
    logic [5:0]  opc;
    logic [5:0]  fn;
    logic [31:0] rs;
    logic [31:0] rt;
    logic [4:0]  sh;
    logic [15:0] im;
    logic [31:0] expRes;
    logic        expOvf;
    logic        expResv;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 36;
  localparam vec_t VECS [NV] = '{
    // R1 add / addu / sub
    '{6'h00, 6'h20, 32'd5,         32'd7,         5'd0,  16'h0000, 32'd12,        1'b0, 1'b0, 8'd1},
    '{6'h00, 6'h21, 32'hFFFFFFFF,  32'd1,         5'd0,  16'h0000, 32'h00000000,  1'b0, 1'b0, 8'd1},
    '{6'h00, 6'h22, 32'd3,         32'd5,         5'd0,  16'h0000, 32'hFFFFFFFE,  1'b0, 1'b0, 8'd1},
    // R3 wrapping forms never trap, signed forms do
    '{6'h00, 6'h23, 32'h80000000,  32'd1,         5'd0,  16'h0000, 32'h7FFFFFFF,  1'b0, 1'b0, 8'd3},
    '{6'h00, 6'h20, 32'h7FFFFFFF,  32'd1,         5'd0,  16'h0000, 32'h80000000,  1'b1, 1'b0, 8'd3},
    '{6'h00, 6'h22, 32'h80000000,  32'd1,         5'd0,  16'h0000, 32'h7FFFFFFF,  1'b1, 1'b0, 8'd3},
    '{6'h08, 6'h3F, 32'h7FFFFFFF,  32'd0,         5'd0,  16'h0001, 32'h80000000,  1'b1, 1'b0, 8'd3},
    '{6'h09, 6'h00, 32'h7FFFFFFF,  32'd0,         5'd0,  16'h0001, 32'h80000000,  1'b0, 1'b0, 8'd3},
    // R4 immediate extension
    '{6'h08, 6'h00, 32'd10,        32'd0,         5'd0,  16'hFFFF, 32'd9,         1'b0, 1'b0, 8'd4},
    '{6'h0C, 6'h00, 32'hFFFFFFFF,  32'd0,         5'd0,  16'h8000, 32'h00008000,  1'b0, 1'b0, 8'd4},
    '{6'h0D, 6'h00, 32'h12340000,  32'd0,         5'd0,  16'hFFFF, 32'h1234FFFF,  1'b0, 1'b0, 8'd4},
    '{6'h0E, 6'h00, 32'hFFFF0000,  32'd0,         5'd0,  16'h8001, 32'hFFFF8001,  1'b0, 1'b0, 8'd4},
    // R2 logic
    '{6'h00, 6'h24, 32'hF0F0F0F0,  32'hFF00FF00,  5'd0,  16'h0000, 32'hF000F000,  1'b0, 1'b0, 8'd2},
    '{6'h00, 6'h25, 32'hF0F0F0F0,  32'hFF00FF00,  5'd0,  16'h0000, 32'hFFF0FFF0,  1'b0, 1'b0, 8'd2},
    '{6'h00, 6'h26, 32'hF0F0F0F0,  32'hFF00FF00,  5'd0,  16'h0000, 32'h0FF00FF0,  1'b0, 1'b0, 8'd2},
    '{6'h00, 6'h27, 32'hF0F0F0F0,  32'hFF00FF00,  5'd0,  16'h0000, 32'h000F000F,  1'b0, 1'b0, 8'd2},
    // R5 upper immediate
    '{6'h0F, 6'h00, 32'hFFFFFFFF,  32'hFFFFFFFF,  5'd0,  16'hABCD, 32'hABCD0000,  1'b0, 1'b0, 8'd5},
    // R6 compares
    '{6'h00, 6'h2A, 32'hFFFFFFFF,  32'd1,         5'd0,  16'h0000, 32'd1,         1'b0, 1'b0, 8'd6},
    '{6'h00, 6'h2B, 32'hFFFFFFFF,  32'd1,         5'd0,  16'h0000, 32'd0,         1'b0, 1'b0, 8'd6},
    '{6'h0A, 6'h00, 32'hFFFFFFFE,  32'd0,         5'd0,  16'hFFFF, 32'd1,         1'b0, 1'b0, 8'd6},
    '{6'h0B, 6'h00, 32'd5,         32'd0,         5'd0,  16'hFFFF, 32'd1,         1'b0, 1'b0, 8'd6},
    '{6'h0B, 6'h00, 32'hFFFFFFFF,  32'd0,         5'd0,  16'hFFFF, 32'd0,         1'b0, 1'b0, 8'd6},
    '{6'h00, 6'h2A, 32'h80000000,  32'h7FFFFFFF,  5'd0,  16'h0000, 32'd1,         1'b0, 1'b0, 8'd6},
    // R7 fixed shifts, rs ignored
    '{6'h00, 6'h00, 32'hFFFFFFFF,  32'h00000001,  5'd31, 16'h0000, 32'h80000000,  1'b0, 1'b0, 8'd7},
    // R9 fill rules
    '{6'h00, 6'h02, 32'hFFFFFFFF,  32'h80000000,  5'd4,  16'h0000, 32'h08000000,  1'b0, 1'b0, 8'd9},
    '{6'h00, 6'h03, 32'd0,         32'h80000000,  5'd4,  16'h0000, 32'hF8000000,  1'b0, 1'b0, 8'd9},
    '{6'h00, 6'h03, 32'd0,         32'h40000000,  5'd30, 16'h0000, 32'h00000001,  1'b0, 1'b0, 8'd9},
    // R8 variable shifts use rs[4:0], shamt ignored
    '{6'h00, 6'h04, 32'h00000024,  32'h0000000F,  5'd31, 16'h0000, 32'h000000F0,  1'b0, 1'b0, 8'd8},
    '{6'h00, 6'h06, 32'hFFFFFFE8,  32'hFF000000,  5'd3,  16'h0000, 32'h00FF0000,  1'b0, 1'b0, 8'd8},
    '{6'h00, 6'h07, 32'h00000021,  32'h80000000,  5'd9,  16'h0000, 32'hC0000000,  1'b0, 1'b0, 8'd8},
    // R10 reserved pairs
    '{6'h00, 6'h01, 32'h12345678,  32'h9ABCDEF0,  5'd3,  16'h0000, 32'd0,         1'b0, 1'b1, 8'd10},
    '{6'h23, 6'h20, 32'h12345678,  32'h9ABCDEF0,  5'd0,  16'h1234, 32'd0,         1'b0, 1'b1, 8'd10},
    '{6'h02, 6'h00, 32'hFFFFFFFF,  32'hFFFFFFFF,  5'd0,  16'hFFFF, 32'd0,         1'b0, 1'b1, 8'd10},
    '{6'h00, 6'h08, 32'hFFFFFFFF,  32'd1,         5'd0,  16'h0000, 32'd0,         1'b0, 1'b1, 8'd10},
    '{6'h00, 6'h18, 32'd7,         32'd9,         5'd0,  16'h0000, 32'd0,         1'b0, 1'b1, 8'd10},
    // R10 with R3: reserved opcode carrying the add function code and overflowing operands
    '{6'h01, 6'h20, 32'h7FFFFFFF,  32'd1,         5'd0,  16'h0001, 32'd0,         1'b0, 1'b1, 8'd10}
  };

  task automatic check(input int req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL R%0d %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [5:0] o, input logic [5:0] f, input logic [31:0] a,
                       input logic [31:0] b, input logic [4:0] s, input logic [15:0] i);
    @(negedge clk);
    opcode = o; funct = f; rsVal = a; rtVal = b; shamt = s; imm = i;
    @(posedge clk);
    #2ns;
  endtask

  function automatic logic [31:0] flagWord(input logic o, input logic r, input logic [4:0] e);
    return {25'd0, o, r, e};
  endfunction

  function automatic logic [4:0] expCode(input logic o, input logic r);
    return o ? 5'h0C : (r ? 5'h0A : 5'h00);
  endfunction

  initial begin : watchdog
    #2ms;
    if (!finished) begin
      failCount++;
      checkCount++;
      $display("FAIL R0 watchdog: actual 0x%08h expected 0x%08h", 32'd1, 32'd0);
      $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
      $finish;
    end
  end

  initial begin : stim
    // idle state: all-zero inputs decode as sll by 0 of zero (R7, R10 no exception)
    @(posedge clk);
    #2ns;
    check(7, "idle result", result, 32'd0);
    check(10, "idle flags", flagWord(ovfTrap, resvInstr, excCode), 32'd0);

    for (int v = 0; v < NV; v++) begin
      drive(VECS[v].opc, VECS[v].fn, VECS[v].rs, VECS[v].rt, VECS[v].sh, VECS[v].im);
      check(int'(VECS[v].req), $sformatf("vector %0d result", v), result, VECS[v].expRes);
      check(int'(VECS[v].req), $sformatf("vector %0d flags", v),
            flagWord(ovfTrap, resvInstr, excCode),
            flagWord(VECS[v].expOvf, VECS[v].expResv, expCode(VECS[v].expOvf, VECS[v].expResv)));
    end

    // R4: addi sign-extends a negative immediate onto zero
    drive(6'h08, 6'h00, 32'd0, 32'd0, 5'd0, 16'h8000);
    check(4, "addi sign extension", result, 32'hFFFF8000);

    // R3: sub of min minus max overflows with wrapped result
    drive(6'h00, 6'h22, 32'h80000000, 32'h7FFFFFFF, 5'd0, 16'd0);
    check(3, "sub wrap value", result, 32'd1);
    check(3, "sub trap code", {27'd0, excCode}, 32'h0000000C);

    // R7 and R9 sweeps over every fixed amount
    for (int s = 0; s < 32; s++) begin
      drive(6'h00, 6'h00, 32'hA5A5A5A5, 32'd1, 5'(s), 16'd0);
      check(7, $sformatf("sll by %0d", s), result, 32'd1 << s);
      drive(6'h00, 6'h03, 32'hA5A5A5A5, 32'h80000000, 5'(s), 16'd0);
      check(9, $sformatf("sra by %0d", s), result, 32'($signed(32'h80000000) >>> s));
    end

    // R8 and R9: srlv with upper rs bits set
    for (int s = 0; s < 32; s++) begin
      drive(6'h00, 6'h06, 32'hFFFFFFE0 | 32'(s), 32'hFFFFFFFF, 5'd17, 16'd0);
      check(8, $sformatf("srlv by %0d", s), result, 32'hFFFFFFFF >> s);
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

endmodule